// File: doc/BRIEF.md
# Time-Slot Bit Channel Extractor

This block picks the bits of a single data-link channel out of a framed serial T1/E1 line stream. Every line bit arrives with a valid strobe and a set of tags. The tags give the time slot the bit belongs to, its position inside that slot, whether the current frame is odd or even, and the number of the link that carries it. The block passes on the bits that match its channel settings. It presents them one at a time, in the order they arrived, with a one-cycle valid pulse, to a downstream HDLC deframer.

The channel is described by four settings: a link number, a time-slot number, an eight-bit mask over the bit positions of the slot, and a two-bit frame filter. Settings are written into a staging copy at any time. They become active only at a frame start, which is marked by a strobe on the first bit of a frame. A frame is therefore never split between two sets of settings.

Top module: `bit_chan_extract`

## Requirements
- R1: After reset, the staged and active link, slot, mask and frame filter are all zero. With the filter at 00, no output pulse appears until new settings are committed.
- R2: A bit is taken only when its time-slot tag equals the active slot setting.
- R3: Mask bit i selects the bit whose position tag is i. Position 0 is the first bit of the slot on the line, and a mask bit of 1 means the bit is taken.
- R4: Frame filter 00 takes no bits at all. This setting is used for loopback.
- R5: Frame filter 01 takes bits only while the frame parity input is 0 (even frame). Filter 10 takes bits only while it is 1 (odd frame).
- R6: Frame filter 11 takes bits from every frame, whatever the parity.
- R7: A bit is taken only when its link tag equals the active link setting.
- R8: For each taken bit, out_vld is high for exactly the one cycle after the bit's input cycle, and out_bit equals the line bit. Bits that are not taken, and cycles with bit_vld low, give out_vld low.
- R9: A settings write changes the active settings only at the next bit marked as frame start, and that bit already uses the new settings. A write made in the same cycle as a frame-start bit waits for the following frame start.
- R10: When several writes occur between two frame starts, only the last one takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_vld | input | 1 | A line bit is present this cycle |
| line_bit | input | 1 | Line data bit |
| frame_sof | input | 1 | This bit is the first of a frame (settings commit point) |
| frame_odd | input | 1 | Frame parity: 1 odd, 0 even |
| slot_num | input | 5 | Time-slot tag of the bit |
| bit_pos | input | 3 | Position of the bit inside its slot, 0 first |
| link_num | input | 5 | Link tag of the bit |
| cfg_wr | input | 1 | Write the staged settings from the cfg_* inputs |
| cfg_link | input | 5 | Link number setting |
| cfg_slot | input | 5 | Time-slot setting |
| cfg_mask | input | 8 | Bit-position mask setting |
| cfg_fsel | input | 2 | Frame filter setting |
| out_vld | output | 1 | Extracted bit valid pulse |
| out_bit | output | 1 | Extracted bit |

## Verification
The bench uses the block at its fixed widths, but narrows the stimulus to a frame of four slots over two interleaved links. This keeps a complete sweep small. For every combination of the four frame filters, four mask patterns, two slot choices and two link choices, it sends one even and one odd frame. Each line bit is compared with a model that is computed arithmetically in the bench. Settings writes are placed in the middle of frames, so every run also covers the commit timing. Dedicated sequences cover a write in the same cycle as a frame start, repeated writes, idle cycles and the behaviour after reset.

// File: rtl/bce_pkg.sv
package bce_pkg;

    localparam int SLOT_W    = 5;
    localparam int LINK_W    = 5;
    localparam int SLOT_BITS = 8;
    localparam int POS_W     = $clog2(SLOT_BITS);

    typedef enum logic [1:0] {
        FSEL_NONE = 2'b00,
        FSEL_EVEN = 2'b01,
        FSEL_ODD  = 2'b10,
        FSEL_ALL  = 2'b11
    } fsel_e;

    typedef struct packed {
        logic [LINK_W-1:0]    link;
        logic [SLOT_W-1:0]    slot;
        logic [SLOT_BITS-1:0] mask;
        fsel_e                fsel;
    } chan_cfg_t;

    typedef struct packed {
        logic              vld;
        logic              data;
        logic              sof;
        logic              odd;
        logic [SLOT_W-1:0] slot;
        logic [POS_W-1:0]  pos;
        logic [LINK_W-1:0] link;
    } line_bit_t;

    localparam chan_cfg_t CFG_RESET = '{link: '0, slot: '0, mask: '0, fsel: FSEL_NONE};

    function automatic logic frame_pass(input fsel_e f, input logic odd);
        case (f)
            FSEL_EVEN: frame_pass = !odd;
            FSEL_ODD:  frame_pass = odd;
            FSEL_ALL:  frame_pass = 1'b1;
            default:   frame_pass = 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/bce_cfg_shadow.sv
module bce_cfg_shadow
    import bce_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      wr_en,
    input  chan_cfg_t wr_cfg,
    input  logic      commit,
    output chan_cfg_t eff_cfg
);

    chan_cfg_t staged_q;
    chan_cfg_t active_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            staged_q <= CFG_RESET;
        end else if (wr_en) begin
            staged_q <= wr_cfg;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= CFG_RESET;
        end else if (commit) begin
            active_q <= staged_q;
        end
    end

    // The frame-start bit is judged by the settings it commits.
    always_comb begin
        eff_cfg = commit ? staged_q : active_q;
    end

    assert_active_holds_R9: assert property (@(posedge clk) disable iff (rst)
        !commit |=> $stable(active_q));

    assert_commit_loads_R10: assert property (@(posedge clk) disable iff (rst)
        commit |=> (active_q == $past(staged_q)));

endmodule

// File: rtl/bce_bit_select.sv
module bce_bit_select
    import bce_pkg::*;
(
    input  line_bit_t lb,
    input  chan_cfg_t cfg,
    output logic      take
);

    logic link_hit;
    logic slot_hit;
    logic mask_hit;
    logic frame_hit;

    always_comb begin
        link_hit  = (lb.link == cfg.link);
        slot_hit  = (lb.slot == cfg.slot);
        mask_hit  = cfg.mask[lb.pos];
        frame_hit = frame_pass(cfg.fsel, lb.odd);
        take      = lb.vld && link_hit && slot_hit && mask_hit && frame_hit;
    end

endmodule

// File: rtl/bce_out_stage.sv
module bce_out_stage (
    input  logic clk,
    input  logic rst,
    input  logic take,
    input  logic data,
    output logic out_vld,
    output logic out_bit
);

    always_ff @(posedge clk) begin
        if (rst) begin
            out_vld <= 1'b0;
            out_bit <= 1'b0;
        end else begin
            out_vld <= take;
            out_bit <= take ? data : 1'b0;
        end
    end

endmodule

// File: rtl/bit_chan_extract.sv
module bit_chan_extract
    import bce_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_vld,
    input  logic              line_bit,
    input  logic              frame_sof,
    input  logic              frame_odd,
    input  logic [SLOT_W-1:0] slot_num,
    input  logic [POS_W-1:0]  bit_pos,
    input  logic [LINK_W-1:0] link_num,
    input  logic              cfg_wr,
    input  logic [LINK_W-1:0] cfg_link,
    input  logic [SLOT_W-1:0] cfg_slot,
    input  logic [SLOT_BITS-1:0] cfg_mask,
    input  logic [1:0]        cfg_fsel,
    output logic              out_vld,
    output logic              out_bit
);

    line_bit_t lb;
    chan_cfg_t wr_cfg;
    chan_cfg_t eff_cfg;
    logic      commit;
    logic      take;

    always_comb begin
        lb.vld  = bit_vld;
        lb.data = line_bit;
        lb.sof  = frame_sof;
        lb.odd  = frame_odd;
        lb.slot = slot_num;
        lb.pos  = bit_pos;
        lb.link = link_num;
        wr_cfg.link = cfg_link;
        wr_cfg.slot = cfg_slot;
        wr_cfg.mask = cfg_mask;
        wr_cfg.fsel = fsel_e'(cfg_fsel);
        commit = bit_vld && frame_sof;
    end

    bce_cfg_shadow u_cfg (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (cfg_wr),
        .wr_cfg (wr_cfg),
        .commit (commit),
        .eff_cfg(eff_cfg)
    );

    bce_bit_select u_sel (
        .lb  (lb),
        .cfg (eff_cfg),
        .take(take)
    );

    bce_out_stage u_out (
        .clk    (clk),
        .rst    (rst),
        .take   (take),
        .data   (line_bit),
        .out_vld(out_vld),
        .out_bit(out_bit)
    );

    assert_out_needs_input_R8: assert property (@(posedge clk) disable iff (rst)
        out_vld |-> $past(bit_vld));

    assert_out_data_R8: assert property (@(posedge clk) disable iff (rst)
        out_vld |-> (out_bit == $past(line_bit)));

    assert_slot_match_R2: assert property (@(posedge clk) disable iff (rst)
        out_vld |-> ($past(slot_num) == $past(eff_cfg.slot)));

    assert_link_match_R7: assert property (@(posedge clk) disable iff (rst)
        out_vld |-> ($past(link_num) == $past(eff_cfg.link)));

    assert_mask_bit_R3: assert property (@(posedge clk) disable iff (rst)
        out_vld |-> $past(eff_cfg.mask[bit_pos]));

    assert_filter_none_R4: assert property (@(posedge clk) disable iff (rst)
        out_vld |-> ($past(eff_cfg.fsel) != FSEL_NONE));

    assert_parity_R5: assert property (@(posedge clk) disable iff (rst)
        out_vld && ($past(eff_cfg.fsel) == FSEL_EVEN) |-> !$past(frame_odd));

endmodule

// File: tb/tb_bit_chan_extract.sv
module tb_bit_chan_extract;

    logic       clk = 1'b0;
    logic       rst;
    logic       bit_vld, line_bit, frame_sof, frame_odd;
    logic [4:0] slot_num, link_num;
    logic [2:0] bit_pos;
    logic       cfg_wr;
    logic [4:0] cfg_link, cfg_slot;
    logic [7:0] cfg_mask;
    logic [1:0] cfg_fsel;
    logic       out_vld, out_bit;

    int checks = 0;
    int fails  = 0;
    logic [15:0] lfsr = 16'hACE1;

    // bench model of staged and active settings: {link, slot, mask, fsel}
    logic [19:0] m_stage, m_act;

    always #2 clk = ~clk;

    bit_chan_extract dut (
        .clk(clk), .rst(rst), .bit_vld(bit_vld), .line_bit(line_bit),
        .frame_sof(frame_sof), .frame_odd(frame_odd), .slot_num(slot_num),
        .bit_pos(bit_pos), .link_num(link_num), .cfg_wr(cfg_wr),
        .cfg_link(cfg_link), .cfg_slot(cfg_slot), .cfg_mask(cfg_mask),
        .cfg_fsel(cfg_fsel), .out_vld(out_vld), .out_bit(out_bit)
    );

    task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic write_cfg(input logic [4:0] lk, input logic [4:0] sl,
                             input logic [7:0] mk, input logic [1:0] fs);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_link = lk; cfg_slot = sl; cfg_mask = mk; cfg_fsel = fs;
        m_stage = {lk, sl, mk, fs};
        @(posedge clk); #1;
        cfg_wr = 1'b0;
    endtask

    // Send one line bit, optionally with a concurrent settings write.
    task automatic send(input logic sof, input logic odd, input logic [4:0] sl,
                        input logic [2:0] ps, input logic [4:0] lk, input logic wr,
                        input logic [19:0] wcfg);
        logic d, exp_v, fpass;
        logic [1:0] fs;
        string tag;
        @(negedge clk);
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        d = lfsr[0];
        bit_vld = 1'b1; line_bit = d; frame_sof = sof; frame_odd = odd;
        slot_num = sl; bit_pos = ps; link_num = lk;
        if (sof) m_act = m_stage;          // R9: frame-start bit uses committed values
        if (wr) begin
            cfg_wr = 1'b1;
            {cfg_link, cfg_slot, cfg_mask, cfg_fsel} = wcfg;
        end
        fs = m_act[1:0];
        case (fs)
            2'b01:   fpass = !odd;
            2'b10:   fpass = odd;
            2'b11:   fpass = 1'b1;
            default: fpass = 1'b0;
        endcase
        exp_v = (lk == m_act[19:15]) && (sl == m_act[14:10]) && m_act[2 + ps] && fpass;
        if (fs == 2'b00)              tag = "R4";
        else if (!fpass)              tag = "R5";
        else if (lk != m_act[19:15])  tag = "R7";
        else if (sl != m_act[14:10])  tag = "R2";
        else if (!m_act[2 + ps])      tag = "R3";
        else if (fs == 2'b11)         tag = "R6";
        else                          tag = "R8";
        @(posedge clk); #1;
        if (wr) begin
            cfg_wr = 1'b0;
            m_stage = wcfg;               // write lands after the commit: R9
        end
        bit_vld = 1'b0; frame_sof = 1'b0;
        check(tag, {out_vld, out_vld & out_bit}, {exp_v, exp_v & d});
    endtask

    task automatic frame(input logic odd, input int mid_wr, input logic [19:0] wcfg);
        for (int s = 0; s < 4; s++) begin
            for (int p = 0; p < 8; p++) begin
                send((s == 0 && p == 0), odd, 5'(s), 3'(p), 5'((s + p) % 2),
                     (s * 8 + p == mid_wr), wcfg);
            end
        end
    endtask

    task automatic idle_check();
        @(negedge clk);
        bit_vld = 1'b0;
        @(posedge clk); #1;
        check("R8", {1'b0, out_vld}, 2'b00);
    endtask

    initial begin
        #(4 * 200000);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] masks [4];
        masks[0] = 8'hA5; masks[1] = 8'hFF; masks[2] = 8'h01; masks[3] = 8'h80;
        rst = 1'b1; bit_vld = 0; line_bit = 0; frame_sof = 0; frame_odd = 0;
        slot_num = 0; bit_pos = 0; link_num = 0; cfg_wr = 0;
        cfg_link = 0; cfg_slot = 0; cfg_mask = 0; cfg_fsel = 0;
        m_stage = '0; m_act = '0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        check("R1", {out_vld, out_bit}, 2'b00);
        // R1: reset settings take nothing even with all-zero tags
        frame(1'b0, -1, '0);
        frame(1'b1, -1, '0);

        // Sweep: settings written mid-frame, committed at next frame start (R9)
        for (int f = 0; f < 4; f++)
            for (int m = 0; m < 4; m++)
                for (int sl = 1; sl < 3; sl++)
                    for (int lk = 0; lk < 2; lk++) begin
                        frame(1'b0, 13, {5'(lk), 5'(sl), masks[m], 2'(f)});
                        frame(1'b1, -1, '0);
                        frame(1'b0, -1, '0);
                    end

        // R9: write in the same cycle as a frame start waits a frame
        write_cfg(5'd0, 5'd0, 8'hFF, 2'b11);
        frame(1'b0, 0, {5'd1, 5'd1, 8'hFF, 2'b11});
        frame(1'b1, -1, '0);

        // R10: several writes before a frame start, the last one wins
        write_cfg(5'd0, 5'd2, 8'h0F, 2'b11);
        write_cfg(5'd1, 5'd3, 8'hF0, 2'b10);
        write_cfg(5'd0, 5'd2, 8'h3C, 2'b01);
        frame(1'b0, -1, '0);
        frame(1'b1, -1, '0);

        // R8: no pulse on idle cycles
        for (int i = 0; i < 4; i++) idle_check();

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule